// File: doc/BRIEF.md
# Temperature Monitor Status and Alert Logic

This block gathers the per-channel event flags of a multi-channel temperature monitor: above high limit, below low limit, above the critical limit, and external diode fault. Each flag is caught in a sticky per-channel status register. A one-byte summary register shows, per kind of event, whether any channel has one pending. The same byte also carries the live converter-busy indication.

Two active-low outputs come from this state. The alert output flags limit and fault events. It can be masked, and it runs in one of two modes. In interrupt mode it stays low while any latched high, low or fault bit is pending. In comparator mode it follows the live high-limit flags. The critical output stays low while any latched critical-limit bit is pending.

A simple synchronous register port gives read access to all status registers. It also gives read and write access to a small configuration register, which is reachable at two addresses. One configuration bit controls an exported run-enable signal.

Top module: `tmon_status_top`

## Requirements
- R1: After reset, every status register reads 00h, configuration reads 00h, alert_n and therm_n are 1 and run_en is 1.
- R2: A flag input that is 1 at a clock edge sets bit i (channel i) of its status register: high at 10h, low at 11h, critical at 12h, fault at 13h. The bit stays set after the flag returns to 0.
- R3: The summary register at 02h is read-only. Bit 7 is the live busy_i input; bits 4, 3, 2 and 1 are the OR of the high, low, fault and critical registers; bits 6, 5 and 0 read 0. busy_i never changes alert_n or therm_n.
- R4: A read of a per-channel register returns its current value and then clears every bit whose flag is 0 in that read cycle. A bit whose flag is 1 in that cycle stays set.
- R5: Reading the summary register clears nothing.
- R6: The configuration register is at both 03h and 09h, with one shared storage. Bits 7:5 are stored and bits 4:0 read 0.
- R7: run_en is the inverse of configuration bit 6 (1 means standby).
- R8: With bit 7 = 0 and bit 5 = 0 (interrupt mode), alert_n is 0 exactly while any latched high, low or fault bit is set.
- R9: With bit 7 = 0 and bit 5 = 1 (comparator mode), alert_n is 0 exactly while any live hi_flag_i bit is 1. Latched bits are ignored.
- R10: With bit 7 = 1, alert_n stays 1 in both modes, and the status registers still latch.
- R11: therm_n is 0 exactly while any latched critical bit is set. The mask does not affect it.
- R12: Writes to status addresses are ignored. Reads of unmapped addresses, and rdata while rd_en is 0, give 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_i | input | 1 | Converter mid-conversion |
| hi_flag_i | input | NCH | Per-channel above-high-limit flags |
| lo_flag_i | input | NCH | Per-channel below-low-limit flags |
| th_flag_i | input | NCH | Per-channel above-critical-limit flags |
| flt_flag_i | input | NCH | Per-channel diode fault flags |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally while rd_en is 1 |
| alert_n | output | 1 | Active-low alert |
| therm_n | output | 1 | Active-low critical output |
| run_en | output | 1 | 1 in active mode, 0 in standby |

## Verification
Read data is combinational: it is sampled in the same cycle as rd_en, before the edge that clears the register. A flag asserted before an edge shows up in status, alert_n and therm_n just after that edge. Comparator-mode alert_n and the busy bit follow their inputs with no register delay, so the bench checks them a moment after it drives them, with no clock in between. The bench drives every input just after a rising edge and samples within the same low-to-high window, so each expected value falls in a known cycle.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 8;
  localparam int unsigned NCAT = 4;

  localparam logic [AW-1:0] A_SUMMARY = 8'h02;
  localparam logic [AW-1:0] A_CFG_P   = 8'h03;
  localparam logic [AW-1:0] A_CFG_S   = 8'h09;
  localparam logic [AW-1:0] A_HI      = 8'h10;
  localparam logic [AW-1:0] A_LO      = 8'h11;
  localparam logic [AW-1:0] A_TH      = 8'h12;
  localparam logic [AW-1:0] A_FLT     = 8'h13;

  // summary bit positions, fixed because software decodes them
  localparam int unsigned SB_BUSY = 7;
  localparam int unsigned SB_HI   = 4;
  localparam int unsigned SB_LO   = 3;
  localparam int unsigned SB_FLT  = 2;
  localparam int unsigned SB_TH   = 1;

  localparam int unsigned CB_MASK = 7;
  localparam int unsigned CB_STBY = 6;
  localparam int unsigned CB_COMP = 5;

  typedef struct packed {
    logic mask;
    logic stby;
    logic comp;
  } cfg_t;

  typedef enum logic [1:0] {CAT_HI = 2'd0, CAT_LO = 2'd1, CAT_TH = 2'd2, CAT_FLT = 2'd3} cat_e;

  function automatic logic [AW-1:0] cat_addr(input int unsigned c);
    case (c)
      0:       return A_HI;
      1:       return A_LO;
      2:       return A_TH;
      default: return A_FLT;
    endcase
  endfunction
endpackage

// File: rtl/tmon_flag_bank.sv
module tmon_flag_bank #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] flag_i,
  input  logic           clr_i,
  output logic [NCH-1:0] stat_o
);
  logic [NCH-1:0] stat_q, stat_d;

  // set wins over clear-on-read so an event present during the read is kept
  always_comb begin
    stat_d = stat_q;
    if (clr_i) stat_d = '0;
    stat_d = stat_d | flag_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/tmon_cfg_reg.sv
module tmon_cfg_reg
  import tmon_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output cfg_t          cfg_o
);
  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_i) begin
      cfg_d.mask = wdata_i[CB_MASK];
      cfg_d.stby = wdata_i[CB_STBY];
      cfg_d.comp = wdata_i[CB_COMP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/tmon_alert_gen.sv
module tmon_alert_gen
  import tmon_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  cfg_t           cfg_i,
  input  logic [NCH-1:0] hi_st_i,
  input  logic [NCH-1:0] lo_st_i,
  input  logic [NCH-1:0] flt_st_i,
  input  logic [NCH-1:0] th_st_i,
  input  logic [NCH-1:0] hi_live_i,
  output logic           alert_n,
  output logic           therm_n
);
  logic irq_src, cmp_src, alert_act;

  always_comb begin
    irq_src   = |{hi_st_i, lo_st_i, flt_st_i};
    cmp_src   = |hi_live_i;
    alert_act = !cfg_i.mask && (cfg_i.comp ? cmp_src : irq_src);
    alert_n   = !alert_act;
    therm_n   = !(|th_st_i);
  end
endmodule

// File: rtl/tmon_status_top.sv
module tmon_status_top
  import tmon_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           busy_i,
  input  logic [NCH-1:0] hi_flag_i,
  input  logic [NCH-1:0] lo_flag_i,
  input  logic [NCH-1:0] th_flag_i,
  input  logic [NCH-1:0] flt_flag_i,
  input  logic           rd_en,
  input  logic           wr_en,
  input  logic [7:0]     addr,
  input  logic [7:0]     wdata,
  output logic [7:0]     rdata,
  output logic           alert_n,
  output logic           therm_n,
  output logic           run_en
);
  logic [NCH-1:0] flag_a [NCAT];
  logic [NCH-1:0] stat_a [NCAT];
  logic [NCH-1:0] hi_st, lo_st, th_st, flt_st;
  cfg_t           cfg_q;
  logic           cfg_wr;

  assign flag_a[CAT_HI]  = hi_flag_i;
  assign flag_a[CAT_LO]  = lo_flag_i;
  assign flag_a[CAT_TH]  = th_flag_i;
  assign flag_a[CAT_FLT] = flt_flag_i;

  for (genvar g = 0; g < NCAT; g++) begin : g_bank
    logic clr;
    assign clr = rd_en && (addr == cat_addr(g));
    tmon_flag_bank #(.NCH(NCH)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .flag_i(flag_a[g]),
      .clr_i (clr),
      .stat_o(stat_a[g])
    );
  end

  assign hi_st  = stat_a[CAT_HI];
  assign lo_st  = stat_a[CAT_LO];
  assign th_st  = stat_a[CAT_TH];
  assign flt_st = stat_a[CAT_FLT];

  assign cfg_wr = wr_en && (addr == A_CFG_P || addr == A_CFG_S);

  tmon_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (cfg_wr),
    .wdata_i(wdata),
    .cfg_o  (cfg_q)
  );

  tmon_alert_gen #(.NCH(NCH)) u_alert (
    .cfg_i    (cfg_q),
    .hi_st_i  (hi_st),
    .lo_st_i  (lo_st),
    .flt_st_i (flt_st),
    .th_st_i  (th_st),
    .hi_live_i(hi_flag_i),
    .alert_n  (alert_n),
    .therm_n  (therm_n)
  );

  assign run_en = !cfg_q.stby;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        A_SUMMARY: begin
          rdata[SB_BUSY] = busy_i;
          rdata[SB_HI]   = |hi_st;
          rdata[SB_LO]   = |lo_st;
          rdata[SB_FLT]  = |flt_st;
          rdata[SB_TH]   = |th_st;
        end
        A_CFG_P, A_CFG_S: begin
          rdata[CB_MASK] = cfg_q.mask;
          rdata[CB_STBY] = cfg_q.stby;
          rdata[CB_COMP] = cfg_q.comp;
        end
        A_HI:    rdata[NCH-1:0] = hi_st;
        A_LO:    rdata[NCH-1:0] = lo_st;
        A_TH:    rdata[NCH-1:0] = th_st;
        A_FLT:   rdata[NCH-1:0] = flt_st;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmon_status_sva.sv
module tmon_status_sva
  import tmon_pkg::*;
#(
  parameter int unsigned NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rd_en,
  input logic           wr_en,
  input logic [7:0]     addr,
  input logic [7:0]     wdata,
  input logic [NCH-1:0] hi_flag_i,
  input logic [NCH-1:0] hi_st,
  input logic [NCH-1:0] lo_st,
  input logic [NCH-1:0] flt_st,
  input logic [NCH-1:0] th_st,
  input logic           cfg_mask,
  input logic           cfg_comp,
  input logic           alert_n,
  input logic           therm_n,
  input logic           run_en
);
  a_r2_latch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (|hi_flag_i) |=> ((hi_st & $past(hi_flag_i)) == $past(hi_flag_i)));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_HI && hi_flag_i == '0) |=> (hi_st == '0));

  a_r3_busy_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_comp && hi_st == '0 && lo_st == '0 && flt_st == '0) |-> alert_n);

  a_r7_run_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CFG_S) |=> (run_en == !$past(wdata[CB_STBY])));

  a_r9_comparator_live: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_comp && !cfg_mask && (|hi_flag_i)) |-> !alert_n);

  a_r10_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mask |-> alert_n);

  a_r11_therm_active: assert property (@(posedge clk) disable iff (!rst_n)
    (|th_st) |-> !therm_n);
endmodule

bind tmon_status_top tmon_status_sva #(.NCH(NCH)) u_sva (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .hi_flag_i(hi_flag_i),
  .hi_st    (hi_st),
  .lo_st    (lo_st),
  .flt_st   (flt_st),
  .th_st    (th_st),
  .cfg_mask (cfg_q.mask),
  .cfg_comp (cfg_q.comp),
  .alert_n  (alert_n),
  .therm_n  (therm_n),
  .run_en   (run_en)
);

// File: tb/test_tmon_status_top.sv
`timescale 1ns/100ps
module test_tmon_status_top;
  localparam int unsigned NCH = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           busy_i = 1'b0;
  logic [NCH-1:0] hi_f = '0, lo_f = '0, th_f = '0, flt_f = '0;
  logic           rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]     addr = '0, wdata = '0;
  logic [7:0]     rdata;
  logic           alert_n, therm_n, run_en;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmon_status_top #(.NCH(NCH)) i_tmon_status_top (
    .clk(clk), .rst_n(rst_n), .busy_i(busy_i),
    .hi_flag_i(hi_f), .lo_flag_i(lo_f), .th_flag_i(th_f), .flt_flag_i(flt_f),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .alert_n(alert_n), .therm_n(therm_n), .run_en(run_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    rd_en = 1'b1; addr = a;
    #1;
    d = rdata;
    tick();
    rd_en = 1'b0; addr = 8'h00;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
    wr_en = 1'b0; addr = 8'h00;
  endtask

  task automatic set_cat(input int c, input logic [NCH-1:0] p);
    case (c)
      0: hi_f = p;
      1: lo_f = p;
      2: th_f = p;
      default: flt_f = p;
    endcase
  endtask

  function automatic logic [7:0] cat_a(input int c);
    return 8'h10 + 8'(c);
  endfunction

  // summary bit per category: hi->4, lo->3, th->1, flt->2
  function automatic logic [7:0] cat_sbit(input int c);
    case (c)
      0: return 8'h10;
      1: return 8'h08;
      2: return 8'h02;
      default: return 8'h04;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();

    // R1 reset state
    for (int a = 2; a < 20; a++) begin
      rd(8'(a), d);
      chk("R1 reset reg", d, 8'h00);
    end
    chk("R1 alert_n", {7'd0, alert_n}, 8'h01);
    chk("R1 therm_n", {7'd0, therm_n}, 8'h01);
    chk("R1 run_en", {7'd0, run_en}, 8'h01);

    // R2 R3 R4 R8 R11 sweep every pattern of every category
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < (1 << NCH); p++) begin
        set_cat(c, NCH'(p));
        tick();
        set_cat(c, '0);
        chk("R8 alert after latch", {7'd0, alert_n}, {7'd0, !(p != 0 && c != 2)});
        chk("R11 therm after latch", {7'd0, therm_n}, {7'd0, !(p != 0 && c == 2)});
        rd(8'h02, d);
        chk("R3 summary", d, (p != 0) ? cat_sbit(c) : 8'h00);
        rd(cat_a(c), d);
        chk("R2 latched value", d, 8'(p));
        rd(cat_a(c), d);
        chk("R4 cleared after read", d, 8'h00);
        chk("R8 alert released", {7'd0, alert_n}, 8'h01);
        chk("R11 therm released", {7'd0, therm_n}, 8'h01);
      end
    end

    // R4 flag active during the read keeps its bit
    hi_f = 3'b101;
    tick();
    rd(8'h10, d);
    chk("R4 read with live flag", d, 8'h05);
    hi_f = '0;
    rd(8'h10, d);
    chk("R4 bit held by live flag", d, 8'h05);
    rd(8'h10, d);
    chk("R4 cleared afterwards", d, 8'h00);

    // R5 summary read does not clear
    lo_f = 3'b010; tick(); lo_f = '0;
    rd(8'h02, d); chk("R5 summary first", d, 8'h08);
    rd(8'h02, d); chk("R5 summary second", d, 8'h08);
    rd(8'h11, d); chk("R5 low still set", d, 8'h02);

    // R3 busy reported but no pin effect
    busy_i = 1'b1; #1;
    rd(8'h02, d); chk("R3 busy bit", d, 8'h80);
    chk("R3 busy alert_n", {7'd0, alert_n}, 8'h01);
    chk("R3 busy therm_n", {7'd0, therm_n}, 8'h01);
    busy_i = 1'b0;

    // R6 R7 full config sweep across both addresses
    for (int v = 0; v < 256; v++) begin
      wr(v[0] ? 8'h09 : 8'h03, 8'(v));
      rd(v[0] ? 8'h03 : 8'h09, d);
      chk("R6 shared config", d, 8'(v) & 8'hE0);
      chk("R7 run_en", {7'd0, run_en}, {7'd0, !v[6]});
    end
    wr(8'h03, 8'h00);

    // R10 mask
    wr(8'h03, 8'h80);
    hi_f = 3'b001; tick(); hi_f = '0;
    chk("R10 masked alert", {7'd0, alert_n}, 8'h01);
    th_f = 3'b010; tick(); th_f = '0;
    chk("R11 therm under mask", {7'd0, therm_n}, 8'h00);
    rd(8'h10, d); chk("R10 status still latches", d, 8'h01);
    rd(8'h12, d); chk("R11 therm reg", d, 8'h02);
    wr(8'h03, 8'hA0);
    hi_f = 3'b100; #1;
    chk("R10 masked comparator", {7'd0, alert_n}, 8'h01);
    hi_f = '0; rd(8'h10, d);

    // R9 comparator mode
    wr(8'h09, 8'h20);
    flt_f = 3'b001; tick(); flt_f = '0;
    chk("R9 latched fault ignored", {7'd0, alert_n}, 8'h01);
    hi_f = 3'b010; #1;
    chk("R9 live high", {7'd0, alert_n}, 8'h00);
    tick();
    hi_f = '0; #1;
    chk("R9 latched high ignored", {7'd0, alert_n}, 8'h01);
    wr(8'h09, 8'h00);
    chk("R8 back to interrupt", {7'd0, alert_n}, 8'h00);
    rd(8'h10, d); rd(8'h13, d);
    chk("R8 all clear", {7'd0, alert_n}, 8'h01);

    // R12 writes to status ignored, unmapped reads zero, idle rdata zero
    hi_f = 3'b011; tick(); hi_f = '0;
    wr(8'h10, 8'h00);
    rd(8'h10, d); chk("R12 status write ignored", d, 8'h03);
    wr(8'h11, 8'hFF);
    rd(8'h11, d); chk("R12 status write no set", d, 8'h00);
    rd(8'h55, d); chk("R12 unmapped read", d, 8'h00);
    addr = 8'h03; #1;
    chk("R12 idle rdata", rdata, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule